// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers up to 32 primary interrupt sources and a second bank of sub-sources, and presents them to a processor as two request lines: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Software talks to it through a small 32-bit register port. That port gives access to the primary pending bits, the primary enables, a one-hot "now serving" register and a fast-route selector. It also gives access to the sub-source pending bits and the sub-source enables. Every pending register is cleared by writing ones to the bits to be cleared.

Sub-sources sit behind fixed parent bits of the primary bank. Sub-sources 0 to 2 fold into primary bit 28, sub-sources 3 to 5 into bit 23, 6 to 8 into bit 15, and 9 to 10 into bit 31. A parent bit is requested while any sub-source of its group is both pending and enabled. Each source is built as level-type or edge-type, chosen by parameter. Primary bits 6 and 24 are reserved. An interrupt service routine reads the one-hot serving register to find its source. It clears the source's bit in the primary pending register and then clears the serving register, and the next waiting source is then loaded.

Top module: `cintc_top`

## Requirements
- R1: After reset the primary pending, serving and fast-route registers read 0. The primary enable register reads 0xFFFFFFFF, all masked. The sub-source pending register reads 0 and the sub-source mask reads 0x1FFFFFFF. Both `irq_o` and `fiq_o` are low.
- R2: An edge-type source sets its pending bit on the clock edge after its input rises from 0 to 1. Holding the input high after the bit is cleared does not set it again.
- R3: A level-type source sets its pending bit while its input is 1. When software clears the bit while the input is still 1, the bit reads 0 for one cycle and is set again on the next edge.
- R4: A write of ones to the primary pending register (offset 0x00), the serving register (0x10) or the sub-source pending register (0x18) clears exactly those bits. Bits written as 0 keep their value.
- R5: In the primary mask register (offset 0x08), a bit of 1 keeps that source out of the serving register and off `irq_o`. Its pending bit is still recorded.
- R6: When the serving register (offset 0x10) is zero, on the next edge it loads the one-hot code of the lowest-numbered source that is pending, unmasked and not fast-routed. It then holds that value until software clears it, even if a lower-numbered source becomes pending. `irq_o` is high exactly while it is non-zero.
- R7: A write to the fast-route register (offset 0x04) stores only the lowest set bit of the written value. The selected source is excluded from the serving register. `fiq_o` is high while that source is pending, whatever its mask bit. Writing 0 returns all sources to the normal path.
- R8: Sub-sources 0–2, 3–5, 6–8 and 9–10 drive primary bits 28, 23, 15 and 31 respectively. The `src_i` inputs on those four bits are ignored. A parent bit acts level-type on the OR of its group's pending-and-unmasked sub-sources. The sub-source mask at offset 0x1C uses 1 for disabled. Sub-sources 11 and above feed no parent bit.
- R9: Primary bits 6 and 24 are reserved and never become pending, whatever their inputs do.
- R10: Reads return the registers at offsets 0x00, 0x04, 0x08, 0x10, 0x18 and 0x1C. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Primary source request lines |
| sub_i | input | NUM_SUB | Sub-source request lines |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench clears a level source while its input is still high and checks the one-cycle dip before the bit returns. A design that let set win would never show the clear, and one that let clear stick would lose a live request. The bench also makes a lower-numbered source pending while another one is being served. The serving register must stay put and then hand over to the lowest waiting source; a free-running priority encoder would switch under the handler's feet. For the fast path, the bench feeds several bits to the selector and routes a masked source to `fiq_o`. It then checks that the source never enters the serving register. Last, the bench drives sub-sources from several groups together, plus one unmapped sub-source. This exposes a wrong group fold or a parent bit set from a masked child.

// File: rtl/cintc_pkg.sv
package cintc_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 8;

   localparam logic [ADDR_W-1:0] A_PEND    = 8'h00;
   localparam logic [ADDR_W-1:0] A_FAST    = 8'h04;
   localparam logic [ADDR_W-1:0] A_MASK    = 8'h08;
   localparam logic [ADDR_W-1:0] A_CUR     = 8'h10;
   localparam logic [ADDR_W-1:0] A_SUBPEND = 8'h18;
   localparam logic [ADDR_W-1:0] A_SUBMASK = 8'h1C;

   // Fixed fold of sub-source index onto a primary parent bit; -1 = none.
   function automatic int group_parent(input int idx);
      if (idx >= 0 && idx <= 2)       return 28;
      else if (idx >= 3 && idx <= 5)  return 23;
      else if (idx >= 6 && idx <= 8)  return 15;
      else if (idx >= 9 && idx <= 10) return 31;
      else                            return -1;
   endfunction

   // Sub-sources (below n) that fold into primary bit p.
   function automatic logic [31:0] members_of(input int p, input int n);
      logic [31:0] r;
      r = '0;
      for (int j = 0; j < 32; j++)
         if (j < n && group_parent(j) == p) r[j] = 1'b1;
      return r;
   endfunction

   // Primary bits that are parents of at least one sub-source below n.
   function automatic logic [31:0] parent_mask(input int n);
      logic [31:0] r;
      r = '0;
      for (int j = 0; j < 32; j++)
         if (j < n && group_parent(j) >= 0) r[group_parent(j)] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] lowest_bit(input logic [31:0] v);
      return v & (~v + 32'd1);
   endfunction

endpackage

// File: rtl/cintc_pend_bank.sv
module cintc_pend_bank #(
   parameter int unsigned W     = 32,
   parameter logic [31:0] LEVEL = '0,
   parameter logic [31:0] RSVD  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);

   if (W > 32) begin : g_bad_w
      $error("cintc_pend_bank: W must not exceed 32");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (RSVD[i]) begin : g_rsvd
         assign pend_o[i] = 1'b0;
      end else if (LEVEL[i]) begin : g_level
         logic q;
         // Clear wins in its own cycle; a live line sets the bit again next edge.
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= 1'b0;
            else if (clr_i[i])  q <= 1'b0;
            else if (line_i[i]) q <= 1'b1;
         end
         assign pend_o[i] = q;
      end else begin : g_edge
         logic q;
         logic prev;
         // A rising edge is never lost, even against a clear in the same cycle.
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q    <= 1'b0;
               prev <= 1'b0;
            end else begin
               prev <= line_i[i];
               q    <= (line_i[i] & ~prev) | (q & ~clr_i[i]);
            end
         end
         assign pend_o[i] = q;
      end
   end

   logic unused_rsvd;
   assign unused_rsvd = ^{line_i & RSVD[W-1:0], clr_i & RSVD[W-1:0]};

endmodule

// File: rtl/cintc_prio_pick.sv
module cintc_prio_pick #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] grant_o
);

   logic [W:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_chain
      assign grant_o[i]  = req_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | req_i[i];
   end

endmodule

// File: rtl/cintc_top.sv
module cintc_top
   import cintc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned NUM_SUB   = 29,
   parameter logic [31:0] SRC_LEVEL = 32'h9080_8030,
   parameter logic [31:0] SRC_RSVD  = 32'h0100_0040,
   parameter logic [31:0] SUB_LEVEL = 32'h0000_01FF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SUB-1:0] sub_i,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   output logic               irq_o,
   output logic               fiq_o
);

   localparam logic [31:0] PARENT_MASK = parent_mask(int'(NUM_SUB));
   localparam logic [31:0] SRC_LVL_EFF = SRC_LEVEL | PARENT_MASK;

   if (NUM_SRC != BUS_W) begin : g_bad_src
      $error("cintc_top: NUM_SRC must equal the bus width for the fixed parent map");
   end
   if (NUM_SUB < 11 || NUM_SUB > BUS_W) begin : g_bad_sub
      $error("cintc_top: NUM_SUB must cover sub-sources 0..10 and fit the bus");
   end
   if ((SRC_RSVD & PARENT_MASK) != '0) begin : g_bad_rsvd
      $error("cintc_top: a parent bit cannot be reserved");
   end

   // ---------------- register port decode ----------------
   logic wr_en, wr_pend, wr_fast, wr_mask, wr_cur, wr_subpend, wr_submask;
   assign wr_en      = bus_sel & bus_wr;
   assign wr_pend    = wr_en && (bus_addr == A_PEND);
   assign wr_fast    = wr_en && (bus_addr == A_FAST);
   assign wr_mask    = wr_en && (bus_addr == A_MASK);
   assign wr_cur     = wr_en && (bus_addr == A_CUR);
   assign wr_subpend = wr_en && (bus_addr == A_SUBPEND);
   assign wr_submask = wr_en && (bus_addr == A_SUBMASK);

   // ---------------- sub-source level ----------------
   logic [NUM_SUB-1:0] sub_pend, smask_q, sub_act, sub_clr;
   assign sub_clr = wr_subpend ? bus_wdata[NUM_SUB-1:0] : '0;

   cintc_pend_bank #(
      .W     (NUM_SUB),
      .LEVEL (SUB_LEVEL),
      .RSVD  ('0)
   ) u_sub_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (sub_i),
      .clr_i  (sub_clr),
      .pend_o (sub_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          smask_q <= '1;
      else if (wr_submask) smask_q <= bus_wdata[NUM_SUB-1:0];
   end

   assign sub_act = sub_pend & ~smask_q;

   // ---------------- primary request lines ----------------
   logic [NUM_SRC-1:0] prim_line;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      localparam logic [NUM_SUB-1:0] MEMB = NUM_SUB'(members_of(i, int'(NUM_SUB)));
      if (MEMB != '0) begin : g_parent
         assign prim_line[i] = |(sub_act & MEMB);
      end else begin : g_direct
         assign prim_line[i] = src_i[i];
      end
   end

   logic unused_src;
   assign unused_src = ^(src_i & PARENT_MASK[NUM_SRC-1:0]);

   // ---------------- primary pending ----------------
   logic [NUM_SRC-1:0] pend_q, prim_clr;
   assign prim_clr = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;

   cintc_pend_bank #(
      .W     (NUM_SRC),
      .LEVEL (SRC_LVL_EFF),
      .RSVD  (SRC_RSVD)
   ) u_src_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (prim_line),
      .clr_i  (prim_clr),
      .pend_o (pend_q)
   );

   // ---------------- mask and fast route ----------------
   logic [NUM_SRC-1:0] mask_q, fast_q;
   logic [BUS_W-1:0]   fast_pick;
   assign fast_pick = lowest_bit(bus_wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         fast_q <= '0;
      end else begin
         if (wr_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
         if (wr_fast) fast_q <= fast_pick[NUM_SRC-1:0];
      end
   end

   // ---------------- serving register ----------------
   logic [NUM_SRC-1:0] cand, pick, cur_q;
   assign cand = pend_q & ~mask_q & ~fast_q;

   cintc_prio_pick #(.W(NUM_SRC)) u_pick (
      .req_i   (cand),
      .grant_o (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)            cur_q <= '0;
      else if (wr_cur)       cur_q <= cur_q & ~bus_wdata[NUM_SRC-1:0];
      else if (cur_q == '0)  cur_q <= pick;
   end

   // ---------------- outputs ----------------
   assign irq_o = |cur_q;
   assign fiq_o = |(pend_q & fast_q);

   always_comb begin
      case (bus_addr)
         A_PEND:    bus_rdata = BUS_W'(pend_q);
         A_FAST:    bus_rdata = BUS_W'(fast_q);
         A_MASK:    bus_rdata = BUS_W'(mask_q);
         A_CUR:     bus_rdata = BUS_W'(cur_q);
         A_SUBPEND: bus_rdata = BUS_W'(sub_pend);
         A_SUBMASK: bus_rdata = BUS_W'(smask_q);
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cintc_sva.sv
module cintc_sva
   import cintc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned NUM_SUB   = 29,
   parameter logic [31:0] SRC_RSVD  = 32'h0100_0040
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] fast_q,
   input logic [NUM_SRC-1:0] cur_q,
   input logic [NUM_SUB-1:0] sub_pend,
   input logic [NUM_SUB-1:0] smask_q
);

   logic cur_wr;
   assign cur_wr = bus_sel & bus_wr & (bus_addr == A_CUR);

   logic [NUM_SRC-1:0] cand_chk;
   assign cand_chk = pend_q & ~mask_q & ~fast_q;

   // R6: serving register is one-hot or zero
   a_r6_cur_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cur_q));

   // R6: a loaded serving value holds until software clears it
   a_r6_cur_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q != '0 && !cur_wr) |=> $stable(cur_q));

   // R6: a newly loaded source was an eligible candidate the cycle before
   a_r6_cur_from_cand: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|cur_q) |-> ((cur_q & $past(cand_chk)) != '0));

   // R7: fast-route selector never holds more than one bit
   a_r7_fast_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fast_q));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      localparam logic [NUM_SUB-1:0] MEMB = NUM_SUB'(members_of(i, int'(NUM_SUB)));
      if (MEMB != '0) begin : g_parent
         // R8: a parent bit only rises after an enabled child was pending
         a_r8_parent_from_child: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> ((($past(sub_pend) & ~$past(smask_q)) & MEMB) != '0));
      end else if (!SRC_RSVD[i]) begin : g_direct
         // R2/R3: a direct pending bit only rises after its input was high
         a_r2_set_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> $past(src_i[i]));
      end else begin : g_rsvd
         // R9: reserved bits stay clear across every cycle
         a_r9_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !pend_q[i] && !cur_q[i]);
      end
   end

endmodule

bind cintc_top cintc_sva #(
   .NUM_SRC  (NUM_SRC),
   .NUM_SUB  (NUM_SUB),
   .SRC_RSVD (SRC_RSVD)
) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_i    (src_i),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .pend_q   (pend_q),
   .mask_q   (mask_q),
   .fast_q   (fast_q),
   .cur_q    (cur_q),
   .sub_pend (sub_pend),
   .smask_q  (smask_q)
);

// File: tb/cintc_top_tb_top.sv
module cintc_top_tb_top;
   import cintc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 32;
   localparam int NSUB = 29;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src = '0;
   logic [NSUB-1:0]   sub = '0;
   logic              sel = 1'b0;
   logic              wr = 1'b0;
   logic [7:0]        addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              irq, fiq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cintc_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .sub_i(sub),
      .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd_reg(a, v);
      chk(req, v, exp);
   endtask

   task automatic cleanup();
      src = '0; sub = '0;
      wr_reg(A_SUBMASK, 32'hFFFF_FFFF);
      wr_reg(A_SUBPEND, 32'hFFFF_FFFF);
      wr_reg(A_MASK, 32'hFFFF_FFFF);
      wr_reg(A_FAST, 32'h0);
      wr_reg(A_PEND, 32'hFFFF_FFFF);
      wr_reg(A_CUR, 32'hFFFF_FFFF);
      step();
   endtask

   task automatic t_reset();
      chk_reg("R1 pend", A_PEND, 32'h0);
      chk_reg("R1 mask", A_MASK, 32'hFFFF_FFFF);
      chk_reg("R1 cur", A_CUR, 32'h0);
      chk_reg("R1 fast", A_FAST, 32'h0);
      chk_reg("R1 subpend", A_SUBPEND, 32'h0);
      chk_reg("R1 submask", A_SUBMASK, 32'h1FFF_FFFF);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 fiq", {31'b0, fiq}, 32'h0);
      chk_reg("R10 unmapped 0x0C", 8'h0C, 32'h0);
   endtask

   task automatic t_edge();
      src[10] = 1'b1;
      step();
      chk_reg("R2 edge latched", A_PEND, 32'h0000_0400);
      step();
      chk_reg("R5 masked not served", A_CUR, 32'h0);
      chk("R5 masked irq low", {31'b0, irq}, 32'h0);
      wr_reg(A_MASK, ~32'h0000_0400);
      step();
      chk_reg("R6 served", A_CUR, 32'h0000_0400);
      chk("R6 irq high", {31'b0, irq}, 32'h1);
      wr_reg(A_PEND, 32'h0000_0400);
      wr_reg(A_CUR, 32'h0000_0400);
      chk_reg("R4 pend cleared", A_PEND, 32'h0);
      chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
      step();
      chk_reg("R2 held high no reset", A_PEND, 32'h0);
      src[10] = 1'b0;
      step();
      src[10] = 1'b1;
      step();
      chk_reg("R2 new rise", A_PEND, 32'h0000_0400);
      cleanup();
   endtask

   task automatic t_level();
      src[4] = 1'b1;
      step();
      chk_reg("R3 level set", A_PEND, 32'h0000_0010);
      wr_reg(A_PEND, 32'h0000_0010);
      chk_reg("R3 clear wins", A_PEND, 32'h0);
      step();
      chk_reg("R3 re-set", A_PEND, 32'h0000_0010);
      src[4] = 1'b0;
      wr_reg(A_PEND, 32'h0000_0010);
      step();
      chk_reg("R3 stays clear", A_PEND, 32'h0);
      cleanup();
   endtask

   task automatic t_priority();
      wr_reg(A_MASK, 32'h0);
      src[12] = 1'b1; src[3] = 1'b1;
      step();
      src[12] = 1'b0; src[3] = 1'b0;
      step();
      chk_reg("R6 lowest first", A_CUR, 32'h0000_0008);
      wr_reg(A_PEND, 32'h0000_0008);
      chk_reg("R4 zero bits kept", A_PEND, 32'h0000_1000);
      src[1] = 1'b1;
      step();
      src[1] = 1'b0;
      step();
      chk_reg("R6 holds", A_CUR, 32'h0000_0008);
      wr_reg(A_CUR, 32'h0000_0008);
      step();
      chk_reg("R6 next lowest", A_CUR, 32'h0000_0002);
      wr_reg(A_PEND, 32'h0000_0002);
      wr_reg(A_CUR, 32'h0000_0002);
      step();
      chk_reg("R6 then higher", A_CUR, 32'h0000_1000);
      cleanup();
   endtask

   task automatic t_fast();
      wr_reg(A_FAST, 32'h0000_0A00);
      chk_reg("R7 lowest kept", A_FAST, 32'h0000_0200);
      wr_reg(A_FAST, 32'h0000_1000);
      src[12] = 1'b1;
      step();
      src[12] = 1'b0;
      chk("R7 fiq while masked", {31'b0, fiq}, 32'h1);
      chk("R7 no irq", {31'b0, irq}, 32'h0);
      wr_reg(A_MASK, 32'h0);
      step();
      chk_reg("R7 excluded from serving", A_CUR, 32'h0);
      wr_reg(A_FAST, 32'h0);
      chk("R7 fiq off", {31'b0, fiq}, 32'h0);
      step();
      chk_reg("R7 back to normal path", A_CUR, 32'h0000_1000);
      chk("R7 irq on", {31'b0, irq}, 32'h1);
      cleanup();
   endtask

   task automatic t_cascade();
      sub[4] = 1'b1;
      src[23] = 1'b1;
      step();
      chk_reg("R8 sub pend", A_SUBPEND, 32'h0000_0010);
      chk_reg("R8 masked child no parent", A_PEND, 32'h0);
      wr_reg(A_SUBMASK, 32'h1FFF_FFEF);
      step();
      chk_reg("R8 parent 23", A_PEND, 32'h0080_0000);
      sub[4] = 1'b0; src[23] = 1'b0;
      wr_reg(A_SUBPEND, 32'h0000_0010);
      chk_reg("R4 sub cleared", A_SUBPEND, 32'h0);
      wr_reg(A_PEND, 32'h0080_0000);
      chk_reg("R8 parent cleared", A_PEND, 32'h0);
      sub[9] = 1'b1;
      step();
      sub[9] = 1'b0;
      chk_reg("R8 edge sub", A_SUBPEND, 32'h0000_0200);
      wr_reg(A_SUBMASK, 32'h1FFF_FDFF);
      step();
      chk_reg("R8 parent 31", A_PEND, 32'h8000_0000);
      sub[1] = 1'b1; sub[7] = 1'b1; sub[20] = 1'b1;
      step();
      wr_reg(A_SUBMASK, 32'h1FEF_FD7D);
      step();
      chk_reg("R8 groups 28 15 31, unmapped none", A_PEND, 32'h9000_8000);
      cleanup();
   endtask

   task automatic t_reserved();
      wr_reg(A_MASK, 32'h0);
      src[6] = 1'b1; src[24] = 1'b1;
      step();
      step();
      chk_reg("R9 reserved never pend", A_PEND, 32'h0);
      chk("R9 no irq", {31'b0, irq}, 32'h0);
      chk_reg("R10 unmapped 0x14", 8'h14, 32'h0);
      cleanup();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_level();
      t_priority();
      t_fast();
      t_cascade();
      t_reserved();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule